// File: doc/BRIEF.md
# Macroblock Link Buffer with Ping-Pong Halves

This block sits on the link between two stages of a macroblock-pipelined video encoder, on the receiving side. It holds two buffer halves, each large enough for one macroblock. The upstream stage raises a request once per macroblock period. The block answers through its status outputs and then accepts a burst of words. The burst may arrive at any point in the period, at any rate. Meanwhile the downstream logic reads the other half, which holds the previous macroblock, through a random-access read port.

A period marker ends each macroblock period. If the incoming half is complete when the marker arrives, the two halves swap roles. The new data then becomes readable, and a fresh request can be taken. If the burst has not finished by the marker, the partial data is dropped, the read half is kept, and a sticky underrun flag is raised. A second request inside one period is refused, and it sets a sticky error flag. The burst length is configurable per request, so stages whose data volume changes by chroma format can share one buffer design.

Top module: `mb_link_buffer`

## Requirements
- R1: After reset `ready_o`=1, `busy_o`=0, `fresh_o`=0, `dup_err_o`=0 and `underrun_o`=0.
- R2: A `req_i` pulse while `ready_o`=1 and `mb_tick_i`=0 is accepted. From the next cycle `busy_o`=1 and `ready_o`=0, and `ready_o` and `busy_o` are never both 1.
- R3: While busy, each `wr_valid_i` cycle stores `wr_data_i` at incoming-half addresses 0, 1, 2 and so on. `busy_o` falls in the cycle after the write that reaches the burst length. That length is `cfg_len_i`, sampled at acceptance, with 0 or any value above MB_WORDS meaning MB_WORDS.
- R4: `wr_valid_i` while not busy (before the request or after the burst completes) stores nothing.
- R5: `req_i` while `ready_o`=0 is refused. The ongoing or completed burst is unaffected, and `dup_err_o` becomes 1 in the next cycle and stays 1 until reset.
- R6: `mb_tick_i` while the incoming half is complete swaps the halves. From the next cycle `fresh_o`=1, `ready_o`=1, and the read port returns the burst just received.
- R7: `mb_tick_i` while the incoming half is not complete does not swap. The read half keeps its contents, the partial data is discarded, `fresh_o` becomes 0, `ready_o` becomes 1, and `underrun_o` becomes 1 and stays 1 until reset.
- R8: `rd_data_o` shows the read-half word at `rd_addr_i` one clock after the address is presented.
- R9: A `req_i` or `wr_valid_i` in the same cycle as `mb_tick_i` is ignored. The marker alone decides the outcome.
- R10: Writes into the incoming half never change what the read port returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mb_tick_i | input | 1 | Macroblock period marker, one-cycle pulse |
| req_i | input | 1 | Upstream transfer request, one-cycle pulse |
| cfg_len_i | input | LEN_W | Burst length in words, sampled at request |
| wr_valid_i | input | 1 | Burst word valid |
| wr_data_i | input | DATA_W | Burst word |
| ready_o | output | 1 | Status: incoming half empty, request will be taken |
| busy_o | output | 1 | Status: burst in progress |
| rd_addr_i | input | AW | Read address into the read half |
| rd_data_o | output | DATA_W | Read data, one-cycle latency |
| fresh_o | output | 1 | Read half was refreshed at the last marker |
| dup_err_o | output | 1 | Sticky: a second request came within one period |
| underrun_o | output | 1 | Sticky: a marker came before the burst completed |

## Verification
Status and flag outputs are registered. A request, the write that completes a burst, or a marker each shows up on `ready_o`, `busy_o`, `fresh_o`, `dup_err_o` or `underrun_o` one clock later. The bench drives inputs on the falling edge and checks at the next falling edge, which lands exactly on that clock. Read data is due one clock after the address. The bench pushes each expected word into a queue when it presents the address, and a monitor pops and compares on the falling edge after the edge that registered the read. Reads are placed after swaps, after underruns and in the middle of a burst, so each comparison shows whether the halves swapped.

// File: rtl/mb_link_pkg.sv
package mb_link_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_FULL = 2'd2
  } link_state_e;
endpackage

// File: rtl/mb_link_ctrl.sv
module mb_link_ctrl
  import mb_link_pkg::*;
#(
  parameter int MB_WORDS = 16,
  parameter int LEN_W    = $clog2(MB_WORDS + 1),
  parameter int AW       = $clog2(MB_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mb_tick_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             wr_valid_i,
  output logic             ready_o,
  output logic             busy_o,
  output logic             fresh_o,
  output logic             dup_err_o,
  output logic             underrun_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic             wr_bank_o,
  output logic             rd_bank_o
);

  localparam logic [LEN_W-1:0] FullLen = LEN_W'(MB_WORDS);

  link_state_e      state_q;
  logic [LEN_W-1:0] cnt_q, len_q, len_eff;
  logic             rd_bank_q, fresh_q, dup_q, und_q;
  logic             last_wr;

  // zero or oversize request means a whole macroblock
  always_comb begin
    if (cfg_len_i == '0 || cfg_len_i > FullLen) len_eff = FullLen;
    else                                         len_eff = cfg_len_i;
  end

  assign wr_en_o   = (state_q == ST_FILL) && wr_valid_i && !mb_tick_i;
  assign wr_addr_o = cnt_q[AW-1:0];
  assign wr_bank_o = ~rd_bank_q;
  assign rd_bank_o = rd_bank_q;
  assign last_wr   = wr_en_o && ((cnt_q + LEN_W'(1)) == len_q);

  assign ready_o    = (state_q == ST_IDLE);
  assign busy_o     = (state_q == ST_FILL);
  assign fresh_o    = fresh_q;
  assign dup_err_o  = dup_q;
  assign underrun_o = und_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      len_q     <= '0;
      rd_bank_q <= 1'b0;
      fresh_q   <= 1'b0;
      dup_q     <= 1'b0;
      und_q     <= 1'b0;
    end else if (mb_tick_i) begin
      // marker owns the cycle
      if (state_q == ST_FULL) begin
        rd_bank_q <= ~rd_bank_q;
        fresh_q   <= 1'b1;
      end else begin
        und_q   <= 1'b1;
        fresh_q <= 1'b0;
      end
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      if (req_i) begin
        if (state_q == ST_IDLE) begin
          state_q <= ST_FILL;
          cnt_q   <= '0;
          len_q   <= len_eff;
        end else begin
          dup_q <= 1'b1;
        end
      end
      if (wr_en_o) begin
        cnt_q <= cnt_q + LEN_W'(1);
        if (last_wr) state_q <= ST_FULL;
      end
    end
  end

  p_ready_busy_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && busy_o));

  p_busy_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !mb_tick_i) |=> busy_o);

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (len_q != '0 && cnt_q <= len_q));

  p_dup_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !ready_o && !mb_tick_i) |=> dup_err_o);

  p_dup_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_err_o |=> dup_err_o);

  p_swap_on_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_tick_i && state_q == ST_FULL) |=> (rd_bank_o != $past(rd_bank_o)) && fresh_o);

  p_hold_on_underrun_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mb_tick_i && state_q != ST_FULL) |=> $stable(rd_bank_o) && underrun_o && !fresh_o);

  p_und_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> underrun_o);

  p_tick_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mb_tick_i |=> ready_o);

endmodule

// File: rtl/mb_pingpong_mem.sv
module mb_pingpong_mem #(
  parameter int DATA_W   = 16,
  parameter int MB_WORDS = 16,
  parameter int AW       = $clog2(MB_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_bank_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int NumBanks = 2;

  logic [DATA_W-1:0] bank_rd [NumBanks];
  logic [DATA_W-1:0] rd_q;

  for (genvar b = 0; b < NumBanks; b++) begin : g_bank
    logic [DATA_W-1:0] mem [MB_WORDS];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_bank_i == 1'(b))) mem[wr_addr_i] <= wr_data_i;
    end

    assign bank_rd[b] = mem[rd_addr_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= bank_rd[rd_bank_i];
  end

  assign rd_data_o = rd_q;

  p_wr_not_rd_bank_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_bank_i != rd_bank_i));

endmodule

// File: rtl/mb_link_buffer.sv
module mb_link_buffer #(
  parameter int DATA_W   = 16,
  parameter int MB_WORDS = 16,
  parameter int LEN_W    = $clog2(MB_WORDS + 1),
  parameter int AW       = $clog2(MB_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mb_tick_i,
  input  logic              req_i,
  input  logic [LEN_W-1:0]  cfg_len_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              ready_o,
  output logic              busy_o,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              fresh_o,
  output logic              dup_err_o,
  output logic              underrun_o
);

  logic          wr_en, wr_bank, rd_bank;
  logic [AW-1:0] wr_addr;

  mb_link_ctrl #(
    .MB_WORDS (MB_WORDS),
    .LEN_W    (LEN_W),
    .AW       (AW)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mb_tick_i  (mb_tick_i),
    .req_i      (req_i),
    .cfg_len_i  (cfg_len_i),
    .wr_valid_i (wr_valid_i),
    .ready_o    (ready_o),
    .busy_o     (busy_o),
    .fresh_o    (fresh_o),
    .dup_err_o  (dup_err_o),
    .underrun_o (underrun_o),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_bank_o  (wr_bank),
    .rd_bank_o  (rd_bank)
  );

  mb_pingpong_mem #(
    .DATA_W   (DATA_W),
    .MB_WORDS (MB_WORDS),
    .AW       (AW)
  ) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_bank_i (wr_bank),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data_i),
    .rd_bank_i (rd_bank),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: tb/mb_link_buffer_tb_top.sv
`timescale 1ns/1ps
module mb_link_buffer_tb_top;
  localparam int DATA_W   = 16;
  localparam int MB_WORDS = 16;
  localparam int LEN_W    = $clog2(MB_WORDS + 1);
  localparam int AW       = $clog2(MB_WORDS);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mb_tick = 0, req = 0, wr_valid = 0;
  logic [LEN_W-1:0]  cfg_len = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [AW-1:0]     rd_addr = '0;
  logic ready, busy, fresh, dup_err, underrun;
  logic [DATA_W-1:0] rd_data;

  int n_checks = 0, n_errors = 0;
  logic done = 0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              rd_req = 0, rd_pend = 0;

  always #5 clk = ~clk;

  mb_link_buffer #(.DATA_W(DATA_W), .MB_WORDS(MB_WORDS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mb_tick_i(mb_tick), .req_i(req),
    .cfg_len_i(cfg_len), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .ready_o(ready), .busy_o(busy), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .fresh_o(fresh), .dup_err_o(dup_err), .underrun_o(underrun));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: read data is due one clock after the address
  always_ff @(posedge clk) rd_pend <= rd_req;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [DATA_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, 32'(rd_data), 32'(e));
    end
  end

  task automatic rd_expect(int a, logic [DATA_W-1:0] e, string tag);
    rd_addr = AW'(a);
    rd_req  = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pulse_req();
    req = 1'b1; @(negedge clk); req = 1'b0;
  endtask

  task automatic pulse_tick();
    mb_tick = 1'b1; @(negedge clk); mb_tick = 1'b0;
  endtask

  task automatic burst(int n, int base);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = DATA_W'(base + i);
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(ready), 1); chk("R1 busy", 32'(busy), 0);
    chk("R1 fresh", 32'(fresh), 0); chk("R1 dup", 32'(dup_err), 0);
    chk("R1 underrun", 32'(underrun), 0);

    // period 1: length 4
    cfg_len = LEN_W'(4);
    pulse_req();
    chk("R2 busy", 32'(busy), 1); chk("R2 ready", 32'(ready), 0);
    burst(3, 'h100);
    chk("R3 busy mid", 32'(busy), 1);
    burst(1, 'h103);
    chk("R3 busy done", 32'(busy), 0);
    burst(1, 'hDEAD);            // R4 after completion
    pulse_req();                 // R5 refused
    chk("R5 dup", 32'(dup_err), 1); chk("R5 busy", 32'(busy), 0);
    pulse_tick();
    chk("R6 ready", 32'(ready), 1); chk("R6 fresh", 32'(fresh), 1);
    chk("R6 underrun", 32'(underrun), 0);
    for (int i = 0; i < 4; i++) rd_expect(i, DATA_W'('h100 + i), "R6 R8 read");

    // period 2: oversize length clamps to MB_WORDS
    cfg_len = '1;
    burst(1, 'hBEEF);            // R4 before request
    pulse_req();
    burst(8, 'h200);
    rd_expect(1, 'h101, "R10 read during burst");
    chk("R3 busy oversize", 32'(busy), 1);
    burst(8, 'h208);
    chk("R3 clamp done", 32'(busy), 0);
    pulse_tick();
    chk("R5 sticky", 32'(dup_err), 1);
    rd_expect(0, 'h200, "R4 R6 read first");
    rd_expect(15, 'h20F, "R6 read last");

    // period 3: underrun
    cfg_len = LEN_W'(4);
    pulse_req();
    burst(2, 'h300);
    pulse_tick();
    chk("R7 underrun", 32'(underrun), 1); chk("R7 fresh", 32'(fresh), 0);
    chk("R7 ready", 32'(ready), 1);
    rd_expect(0, 'h200, "R7 no swap");

    // period 4: request with marker ignored, last write with marker ignored
    req = 1'b1; mb_tick = 1'b1; @(negedge clk); req = 1'b0; mb_tick = 1'b0;
    chk("R9 req ignored ready", 32'(ready), 1); chk("R9 req ignored busy", 32'(busy), 0);
    chk("R9 no dup change", 32'(dup_err), 1);
    pulse_req();
    burst(3, 'h400);
    wr_valid = 1'b1; wr_data = 'h403; mb_tick = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; mb_tick = 1'b0;
    chk("R9 write at marker ready", 32'(ready), 1);
    chk("R9 fresh", 32'(fresh), 0);
    rd_expect(3, 'h203, "R9 no swap");

    // period 5: normal, overwrites discarded partial data
    pulse_req();
    burst(4, 'h500);
    pulse_tick();
    chk("R6 fresh again", 32'(fresh), 1);
    for (int i = 0; i < 4; i++) rd_expect(i, DATA_W'('h500 + i), "R6 R7 after discard");

    repeat (3) @(negedge clk);
    chk("R8 queue drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule